// File: doc/BRIEF.md
# System Address Decoder with Boot Overlay

This block sits between a 24-bit CPU address bus and the devices of a small computer. For every read or write strobe it classifies the address into exactly one of five regions (boot ROM, main RAM, video RAM, page-map RAM or the I/O space) and registers a one-hot select. Alongside the select it provides a local address, trimmed to that region's size, and a device write enable. Reads that land in the I/O space return a fill word of all ones, sized to the access width.

After reset the decoder runs in overlay mode. Every address has bit 23 forced high before decoding, so the CPU fetches its reset vectors and early code from ROM whatever address it issues. Software leaves overlay mode by writing a control register. The flag bit in that register sits at data bit 7 for byte writes and at data bit 15 for word and long writes. A second register holds four active-low LED drive lines and is loaded by word writes only. Data is big-endian: the byte at the lowest address is the most significant one, so a byte write carries its value in data bits 7:0 and a word or long write carries its low half in bits 15:0.

Top module: `sys_addr_decoder`

## Requirements
- R1: After a synchronous reset, `dev_sel` is 0, `dev_we`, `dev_re` and `fill_valid` are 0, `rom_overlay_off` is 0 and `led_n` is 4'hF.
- R2: While `rom_overlay_off` is 0, bit 23 of the address is forced to 1 before decoding. An access below 0x400000 therefore selects ROM, and an access to 0x400000..0x7FFFFF selects I/O.
- R3: An effective address in 0x800000..0xBFFFFF selects ROM (`dev_sel` bit 0), and `rom_addr` is the address modulo the ROM size. A write to ROM gives `dev_we` = 0.
- R4: An effective address below RAM_BYTES selects RAM (`dev_sel` bit 1), and `ram_addr` is the address modulo RAM_BYTES. RAM_BYTES itself does not select RAM.
- R5: An effective address in 0x420000..0x427FFF selects video RAM (`dev_sel` bit 2), and `vram_addr` is address bits 14:0.
- R6: An effective address in 0x400000..0x4007FF selects map RAM (`dev_sel` bit 3), and `map_addr` is address bits 10:0.
- R7: Any other effective address selects I/O (`dev_sel` bit 4). Exactly one select bit is set in the cycle after a strobed access, and none after a cycle without a strobe. `dev_we` and `dev_re` follow `cpu_wr` and `cpu_rd` one cycle later, except that `dev_we` is 0 for ROM.
- R8: A write to effective address 0xE43000 loads `rom_overlay_off` from data bit 7 when `cpu_size` is 0 (byte), and from data bit 15 when it is 1 (word) or 2 (long). Reads of that address and writes to other addresses leave the flag unchanged.
- R9: A word write (`cpu_size` = 1) to effective address 0x4A0000 loads `led_n` from data bits 11:8. Byte and long writes to that address leave `led_n` unchanged.
- R10: A read that selects I/O gives `fill_valid` = 1 and a `fill_data` of 0x000000FF for a byte, 0x0000FFFF for a word and 0xFFFFFFFF for a long. A `cpu_size` of 3 is treated as long. Any other access gives `fill_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 24 | CPU byte address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_size | input | 2 | Access width: 0 byte, 1 word, 2 long |
| cpu_wdata | input | 16 | Low half of the write data bus |
| dev_sel | output | 5 | One-hot region select: 0 ROM, 1 RAM, 2 video RAM, 3 map RAM, 4 I/O |
| dev_we | output | 1 | Write enable to the selected device |
| dev_re | output | 1 | Read enable to the selected device |
| rom_addr | output | ROM_AW | Local ROM address |
| ram_addr | output | log2(RAM_BYTES) | Local RAM address |
| vram_addr | output | 15 | Local video RAM address |
| map_addr | output | 11 | Local map RAM address |
| fill_data | output | 32 | Data returned for I/O-space reads |
| fill_valid | output | 1 | `fill_data` is valid this cycle |
| rom_overlay_off | output | 1 | 1 once software has left overlay mode |
| led_n | output | 4 | Active-low LED drive lines |

## Verification
A wrong overlay flag shows at `dev_sel` on the very next access. Low addresses that should reach RAM select ROM instead, or the reverse, one cycle after the strobe. Because the bench keeps its own copy of the flag and the LED register and compares them after every access, a bit loaded from the wrong data position is caught at the first write whose two candidate bits differ. A region window off by one appears as a wrong select at the directed boundary addresses just inside and just outside each window.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

  localparam int NUM_REGIONS = 5;

  localparam int RG_ROM  = 0;
  localparam int RG_RAM  = 1;
  localparam int RG_VRAM = 2;
  localparam int RG_MAP  = 3;
  localparam int RG_IO   = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam logic [23:0] OVERLAY_BIT = 24'h80_0000;
  localparam logic [23:0] ROM_LO      = 24'h80_0000;
  localparam logic [23:0] ROM_HI      = 24'hBF_FFFF;
  localparam logic [23:0] VRAM_LO     = 24'h42_0000;
  localparam logic [23:0] VRAM_HI     = 24'h42_7FFF;
  localparam logic [23:0] MAP_LO      = 24'h40_0000;
  localparam logic [23:0] MAP_HI      = 24'h40_07FF;
  localparam logic [23:0] CTL_ADDR    = 24'hE4_3000;
  localparam logic [23:0] LED_ADDR    = 24'h4A_0000;

  localparam int VRAM_AW = 15;
  localparam int MAP_AW  = 11;

endpackage

// File: rtl/addr_dec_region.sv
module addr_dec_region
  import addr_dec_pkg::*;
#(
  parameter int RAM_BYTES = 512 * 1024
) (
  input  logic [23:0]            eff_addr,
  output logic [NUM_REGIONS-1:0] region
);

  localparam logic [24:0] RAM_LIMIT = 25'(RAM_BYTES);

  logic in_rom, in_ram, in_vram, in_map;

  always_comb begin
    in_rom  = (eff_addr >= ROM_LO) && (eff_addr <= ROM_HI);
    in_ram  = ({1'b0, eff_addr} < RAM_LIMIT);
    in_vram = (eff_addr >= VRAM_LO) && (eff_addr <= VRAM_HI);
    in_map  = (eff_addr >= MAP_LO) && (eff_addr <= MAP_HI);
  end

  // Priority: ROM, RAM, video RAM, map RAM, then I/O catches the rest
  always_comb begin
    region = '0;
    if (in_rom)       region[RG_ROM]  = 1'b1;
    else if (in_ram)  region[RG_RAM]  = 1'b1;
    else if (in_vram) region[RG_VRAM] = 1'b1;
    else if (in_map)  region[RG_MAP]  = 1'b1;
    else              region[RG_IO]   = 1'b1;
  end

  always_comb begin
    a_region_onehot_r7: assert ($countones(region) == 1)
      else $error("region decode not one-hot");
  end

endmodule

// File: rtl/addr_dec_fill.sv
module addr_dec_fill
  import addr_dec_pkg::*;
#(
  parameter int FILL_W = 32
) (
  input  logic [1:0]        size,
  output logic [FILL_W-1:0] pattern
);

  localparam int LANES = FILL_W / 8;

  int unsigned live_lanes;

  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: live_lanes = 1;
      SZ_WORD: live_lanes = 2;
      default: live_lanes = LANES;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign pattern[8*g +: 8] = (g < live_lanes) ? 8'hFF : 8'h00;
  end

endmodule

// File: rtl/addr_dec_ctl.sv
module addr_dec_ctl
  import addr_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        io_wr,
  input  logic [23:0] eff_addr,
  input  logic [1:0]  size,
  input  logic [15:0] wdata,
  output logic        overlay_off,
  output logic [3:0]  led_n
);

  logic ctl_hit, led_hit, flag_next;

  always_comb begin
    ctl_hit   = io_wr && (eff_addr == CTL_ADDR);
    led_hit   = io_wr && (eff_addr == LED_ADDR) && (acc_size_e'(size) == SZ_WORD);
    flag_next = (acc_size_e'(size) == SZ_BYTE) ? wdata[7] : wdata[15];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      overlay_off <= 1'b0;
      led_n       <= 4'hF;
    end else begin
      if (ctl_hit) overlay_off <= flag_next;
      if (led_hit) led_n       <= wdata[11:8];
    end
  end

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !io_wr |=> $stable(overlay_off))
    else $error("overlay flag changed without an I/O write");

  p_led_size_r9: assert property (@(posedge clk) disable iff (rst)
    (io_wr && (size != 2'd1)) |=> $stable(led_n))
    else $error("LED register changed on a non-word write");

  p_led_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !io_wr |=> $stable(led_n))
    else $error("LED register changed without an I/O write");

endmodule

// File: rtl/sys_addr_decoder.sv
module sys_addr_decoder
  import addr_dec_pkg::*;
#(
  parameter int RAM_BYTES = 512 * 1024,
  parameter int ROM_AW    = 15,
  parameter int FILL_W    = 32,
  localparam int RAM_AW   = $clog2(RAM_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [23:0]            cpu_addr,
  input  logic                   cpu_rd,
  input  logic                   cpu_wr,
  input  logic [1:0]             cpu_size,
  input  logic [15:0]            cpu_wdata,
  output logic [NUM_REGIONS-1:0] dev_sel,
  output logic                   dev_we,
  output logic                   dev_re,
  output logic [ROM_AW-1:0]      rom_addr,
  output logic [RAM_AW-1:0]      ram_addr,
  output logic [VRAM_AW-1:0]     vram_addr,
  output logic [MAP_AW-1:0]      map_addr,
  output logic [FILL_W-1:0]      fill_data,
  output logic                   fill_valid,
  output logic                   rom_overlay_off,
  output logic [3:0]             led_n
);

  logic [23:0]            eff_addr;
  logic [NUM_REGIONS-1:0] region;
  logic [FILL_W-1:0]      fill_pat;
  logic                   access;

  always_comb begin
    eff_addr = rom_overlay_off ? cpu_addr : (cpu_addr | OVERLAY_BIT);
    access   = cpu_rd || cpu_wr;
  end

  addr_dec_region #(
    .RAM_BYTES (RAM_BYTES)
  ) u_region (
    .eff_addr (eff_addr),
    .region   (region)
  );

  addr_dec_fill #(
    .FILL_W (FILL_W)
  ) u_fill (
    .size    (cpu_size),
    .pattern (fill_pat)
  );

  addr_dec_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .io_wr       (cpu_wr && region[RG_IO]),
    .eff_addr    (eff_addr),
    .size        (cpu_size),
    .wdata       (cpu_wdata),
    .overlay_off (rom_overlay_off),
    .led_n       (led_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_sel    <= '0;
      dev_we     <= 1'b0;
      dev_re     <= 1'b0;
      rom_addr   <= '0;
      ram_addr   <= '0;
      vram_addr  <= '0;
      map_addr   <= '0;
      fill_data  <= '0;
      fill_valid <= 1'b0;
    end else begin
      dev_sel    <= access ? region : '0;
      dev_re     <= cpu_rd;
      dev_we     <= cpu_wr && !region[RG_ROM];
      rom_addr   <= eff_addr[ROM_AW-1:0];
      ram_addr   <= eff_addr[RAM_AW-1:0];
      vram_addr  <= eff_addr[VRAM_AW-1:0];
      map_addr   <= eff_addr[MAP_AW-1:0];
      fill_valid <= cpu_rd && region[RG_IO];
      fill_data  <= (cpu_rd && region[RG_IO]) ? fill_pat : '0;
    end
  end

  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    access |=> ($countones(dev_sel) == 1))
    else $error("select not one-hot after access");

  p_idle_nosel_r7: assert property (@(posedge clk) disable iff (rst)
    !access |=> (dev_sel == '0))
    else $error("select asserted without strobe");

  p_rom_nowe_r3: assert property (@(posedge clk) disable iff (rst)
    dev_sel[RG_ROM] |-> !dev_we)
    else $error("write enable to ROM");

  p_overlay_low_rom_r2: assert property (@(posedge clk) disable iff (rst)
    (!rom_overlay_off && access && (cpu_addr < 24'h40_0000)) |=> dev_sel[RG_ROM])
    else $error("overlay did not steer low address to ROM");

  p_fill_io_r10: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> (dev_sel[RG_IO] && dev_re))
    else $error("fill data outside an I/O read");

endmodule

// File: tb/sim_sys_addr_decoder.sv
module sim_sys_addr_decoder;

  localparam int RAM_BYTES = 512 * 1024;
  localparam int ROM_AW    = 15;
  localparam int RAM_AW    = $clog2(RAM_BYTES);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [1:0]  cpu_size = '0;
  logic [15:0] cpu_wdata = '0;
  logic [4:0]  dev_sel;
  logic        dev_we, dev_re;
  logic [ROM_AW-1:0] rom_addr;
  logic [RAM_AW-1:0] ram_addr;
  logic [14:0] vram_addr;
  logic [10:0] map_addr;
  logic [31:0] fill_data;
  logic        fill_valid;
  logic        rom_overlay_off;
  logic [3:0]  led_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic       m_ovl = 1'b0;
  logic [3:0] m_led = 4'hF;

  always #2 clk = ~clk;

  sys_addr_decoder #(.RAM_BYTES(RAM_BYTES), .ROM_AW(ROM_AW)) u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_size(cpu_size), .cpu_wdata(cpu_wdata), .dev_sel(dev_sel), .dev_we(dev_we),
    .dev_re(dev_re), .rom_addr(rom_addr), .ram_addr(ram_addr), .vram_addr(vram_addr),
    .map_addr(map_addr), .fill_data(fill_data), .fill_valid(fill_valid),
    .rom_overlay_off(rom_overlay_off), .led_n(led_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] m_region(input logic [23:0] e);
    if (e >= 24'h800000 && e <= 24'hBFFFFF) return 5'b00001;
    if (e < 24'(RAM_BYTES))                  return 5'b00010;
    if (e >= 24'h420000 && e <= 24'h427FFF) return 5'b00100;
    if (e >= 24'h400000 && e <= 24'h4007FF) return 5'b01000;
    return 5'b10000;
  endfunction

  function automatic logic [31:0] m_fill(input logic [1:0] sz);
    case (sz)
      2'd0: return 32'h000000FF;
      2'd1: return 32'h0000FFFF;
      default: return 32'hFFFFFFFF;
    endcase
  endfunction

  task automatic access(input logic [23:0] a, input bit r, input bit w,
                        input logic [1:0] sz, input logic [15:0] d);
    logic [23:0] e;
    logic [4:0]  rg;
    string       tag;
    @(negedge clk);
    cpu_addr = a; cpu_rd = r; cpu_wr = w; cpu_size = sz; cpu_wdata = d;
    e  = m_ovl ? a : (a | 24'h800000);
    rg = m_region(e);
    @(posedge clk);
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    // model register updates (take effect at the same edge)
    if (w && rg[4] && e == 24'hE43000) m_ovl = (sz == 2'd0) ? d[7] : d[15];
    if (w && rg[4] && e == 24'h4A0000 && sz == 2'd1) m_led = d[11:8];
    case (1'b1)
      rg[0]: tag = "R3";
      rg[1]: tag = "R4";
      rg[2]: tag = "R5";
      rg[3]: tag = "R6";
      default: tag = "R7";
    endcase
    if (!(e == a)) tag = "R2";
    chk(dev_sel == rg, {tag, " select"}, 32'(dev_sel), 32'(rg));
    if (rg[0]) chk(rom_addr == e[ROM_AW-1:0], "R3 rom_addr", 32'(rom_addr), 32'(e[ROM_AW-1:0]));
    if (rg[1]) chk(ram_addr == e[RAM_AW-1:0], "R4 ram_addr", 32'(ram_addr), 32'(e[RAM_AW-1:0]));
    if (rg[2]) chk(vram_addr == e[14:0], "R5 vram_addr", 32'(vram_addr), 32'(e[14:0]));
    if (rg[3]) chk(map_addr == e[10:0], "R6 map_addr", 32'(map_addr), 32'(e[10:0]));
    chk(dev_we == (w && !rg[0]), rg[0] ? "R3 dev_we" : "R7 dev_we", 32'(dev_we), 32'(w && !rg[0]));
    chk(dev_re == r, "R7 dev_re", 32'(dev_re), 32'(r));
    chk(fill_valid == (r && rg[4]), "R10 fill_valid", 32'(fill_valid), 32'(r && rg[4]));
    if (r && rg[4]) chk(fill_data == m_fill(sz), "R10 fill_data", fill_data, m_fill(sz));
    chk(rom_overlay_off == m_ovl, "R8 overlay flag", 32'(rom_overlay_off), 32'(m_ovl));
    chk(led_n == m_led, "R9 led_n", 32'(led_n), 32'(m_led));
  endtask

  task automatic idle_check();
    @(negedge clk);
    @(negedge clk);
    chk(dev_sel == 5'd0, "R7 idle select", 32'(dev_sel), 32'd0);
    chk(!dev_we && !dev_re, "R7 idle enables", {30'd0, dev_we, dev_re}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed_sink;
    seed_sink = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(dev_sel == 5'd0, "R1 dev_sel", 32'(dev_sel), 32'd0);
    chk(!dev_we && !dev_re && !fill_valid, "R1 strobes", {29'd0, dev_we, dev_re, fill_valid}, 32'd0);
    chk(rom_overlay_off == 1'b0, "R1 overlay flag", 32'(rom_overlay_off), 32'd0);
    chk(led_n == 4'hF, "R1 led_n", 32'(led_n), 32'hF);

    // R2 overlay active
    access(24'h000010, 1, 0, 2'd1, 16'h0);
    access(24'h07FFFE, 1, 0, 2'd2, 16'h0);
    access(24'h420000, 1, 0, 2'd1, 16'h0);
    access(24'h4A0000, 0, 1, 2'd1, 16'h0000);  // lands at 0xCA0000: LED unchanged (R9)
    access(24'h000100, 0, 1, 2'd1, 16'hFFFF);  // R3 ROM write ignored
    // R8 byte write: bit 7 loads flag
    access(24'hE43000, 0, 1, 2'd0, 16'h0080);
    // R4 / R7 RAM boundary
    access(24'h07FFFF, 1, 0, 2'd0, 16'h0);
    access(24'h080000, 1, 0, 2'd0, 16'h0);
    access(24'h000000, 0, 1, 2'd1, 16'h1234);
    // R5 / R6 windows
    access(24'h420000, 1, 0, 2'd1, 16'h0);
    access(24'h427FFF, 0, 1, 2'd0, 16'h0);
    access(24'h428000, 1, 0, 2'd0, 16'h0);
    access(24'h41FFFF, 1, 0, 2'd0, 16'h0);
    access(24'h400000, 1, 0, 2'd1, 16'h0);
    access(24'h4007FF, 0, 1, 2'd0, 16'h0);
    access(24'h400800, 1, 0, 2'd0, 16'h0);
    // R3 ROM window edges
    access(24'h800000, 1, 0, 2'd2, 16'h0);
    access(24'hBFFFFF, 0, 1, 2'd0, 16'h0);
    access(24'hC00000, 1, 0, 2'd1, 16'h0);
    // R9 LED register
    access(24'h4A0000, 0, 1, 2'd1, 16'h0500);
    access(24'h4A0000, 0, 1, 2'd0, 16'h0F00);
    access(24'h4A0000, 0, 1, 2'd2, 16'h0A00);
    access(24'h4A0000, 1, 0, 2'd1, 16'h0);
    // R10 fill widths, including size 3
    access(24'h600000, 1, 0, 2'd0, 16'h0);
    access(24'h600000, 1, 0, 2'd1, 16'h0);
    access(24'h600000, 1, 0, 2'd2, 16'h0);
    access(24'h600000, 1, 0, 2'd3, 16'h0);
    // R8 word write with bit 15 clear but bit 7 set: overlay returns
    access(24'hE43000, 0, 1, 2'd1, 16'h0080);
    access(24'h000020, 1, 0, 2'd1, 16'h0);
    access(24'hE43000, 1, 0, 2'd1, 16'h0);     // read has no effect on the flag
    access(24'hE43000, 0, 1, 2'd2, 16'h8000);  // long: bit 15 sets flag
    access(24'h000020, 1, 0, 2'd1, 16'h0);
    idle_check();

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [23:0] a;
      bit r;
      case ($urandom_range(0, 6))
        0: a = 24'($urandom_range(0, RAM_BYTES - 1));
        1: a = 24'h800000 | 24'($urandom_range(0, 24'h3FFFFF));
        2: a = 24'h420000 | 24'($urandom_range(0, 16'h7FFF));
        3: a = 24'h400000 | 24'($urandom_range(0, 11'h7FF));
        4: a = 24'($urandom);
        5: a = 24'hE43000;
        default: a = 24'h4A0000;
      endcase
      r = $urandom_range(0, 1) == 1;
      access(a, r, !r, 2'($urandom_range(0, 3)), 16'($urandom));
      if (i % 50 == 0) idle_check();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule